// File: doc/BRIEF.md
# Configuration Item Register Front-End

This block is the register face of a firmware configuration device. Software reaches it through a small memory-mapped window that holds three registers. The first is a byte-streaming data register that hands out the contents of the chosen configuration item, a few bytes per read. The second is a 16-bit item selector. The third is a 64-bit descriptor address register that launches transfers on a separate DMA engine. The configuration items live in a read-only store whose contents are computed from parameters. A per-item read offset tracks how far software has read.

Descriptor addresses are held most-significant byte first. Only a write to the lower 32-bit half, or a single 64-bit write, launches a transfer. A host with 32-bit descriptor addresses therefore needs one write. A host with wider addresses writes the upper half and then the lower half. On launch the block raises a one-cycle start pulse and presents the descriptor address. The DMA engine reports completion on a done input, and that clears the register.

The DMA engine reads and moves through the same item through a select/advance side port. As a result, programmed reads and DMA transfers share one cursor. Bus requests use a valid/ready request channel. Read data returns on a valid/ready response channel. At most one read is outstanding: a request is refused while a response waits for `rsp_ready`, and also in any cycle in which the side port acts.

Top module: `cfgfe_top`

## Requirements
- R1: After reset the descriptor address reads zero, no transfer is busy, no response is pending, item 0 is selected and its offset is 0.
- R2: Requests are decoded by start offset: 0x00–0x07 is the data register, 0x08–0x09 the selector, 0x0C–0x13 the descriptor address. Reads elsewhere return zero and writes elsewhere change nothing. Only a 2-byte write at 0x08 updates the selector.
- R3: A 2-byte selector write with value v selects item v and sets its offset to 0. A selector read returns the index, low byte in lane 0.
- R4: A data read of 2^size bytes returns the selected item's bytes from the current offset, the first byte in lane 0. Bytes past the item's end, and lanes beyond the access width, read zero. The offset advances by the width but never beyond the item length.
- R5: Item 0 is 4 bytes holding the little-endian value 0x00000002; bit 1 of that value advertises DMA. Item k (0 < k < N_ITEMS) is k*ITEM_STEP bytes long, and its byte j is ((16k + j) mod 256) XOR 0x3C. Indices of N_ITEMS and above have length 0.
- R6: The descriptor address image is big-endian. Byte offset 0x0C holds bits 63:56 and byte offset 0x13 holds bits 7:0. Reads of that region return this image.
- R7: A 4-byte write at 0x0C only stores the upper half. A 4-byte write at 0x10, or an 8-byte write at 0x0C, stores its bytes and launches a transfer. The launch shows as `dma_start` high for exactly one cycle with `dma_busy` high and `dma_desc` equal to the new address.
- R8: While a transfer is busy, every write to the descriptor address is ignored: no store and no start pulse.
- R9: `dma_done` while busy clears the descriptor address to zero and drops `dma_busy` on the next cycle. `dma_done` while idle has no effect.
- R10: The side port selects an item (offset to 0) or advances the offset by `dma_adv_len`, saturating at the item length. Select wins if both are asserted. `bus_ready` is low in any cycle the side port acts.
- R11: Read data appears with `rsp_valid` the cycle after the request is accepted. It stays valid and stable until `rsp_ready`. `bus_ready` is low while a response is pending.
- R12: Writes to the data register are ignored and leave the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted when high with bus_valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the window |
| bus_size | input | 2 | Access width is 2^bus_size bytes |
| bus_wdata | input | 64 | Write bytes, first byte in lane 0 |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 64 | Read bytes, first byte in lane 0 |
| dma_start | output | 1 | One-cycle launch pulse |
| dma_desc | output | 64 | Descriptor address (native value) |
| dma_busy | output | 1 | Transfer in progress |
| dma_done | input | 1 | Transfer finished |
| dma_sel_en | input | 1 | Side-port item select |
| dma_sel_idx | input | 16 | Side-port item index |
| dma_adv_en | input | 1 | Side-port offset advance |
| dma_adv_len | input | 16 | Side-port advance in bytes |
| cur_item | output | 16 | Selected item index |
| cur_offset | output | 16 | Current offset in the item |
| cur_length | output | 16 | Length of the selected item |

## Verification
The bench builds the block with N_ITEMS = 4 and ITEM_STEP = 5. Item lengths are then 4, 5, 10 and 15 bytes, none a multiple of the 8-byte access width, so wide reads regularly straddle an item's end and hit both the zero-fill and offset saturation. Selector values 4 and 5 reach indices with no item behind them. The small table also lets random traffic mix selects, reads, side-port advances and descriptor launches so that they meet in the same item many times.

// File: rtl/cfgfe_pkg.sv
package cfgfe_pkg;
  localparam int LANES      = 8;
  localparam int BUS_W      = 8 * LANES;
  localparam int DESC_W     = 64;
  localparam int FEATURE_DMA_BIT = 1;
  localparam int SEL_BASE   = 8;
  localparam int SEL_BYTES  = 2;
  localparam int DESC_BASE  = 12;
  localparam int DESC_BYTES = DESC_W / 8;
  localparam int HALF_LO    = DESC_BASE + DESC_BYTES / 2;
  localparam int WIN_BYTES  = DESC_BASE + DESC_BYTES;

  function automatic logic [31:0] item_len_f(input int unsigned idx, input int unsigned n_items,
                                             input int unsigned step);
    if (idx == 0) return 32'd4;
    else if (idx < n_items) return 32'(idx * step);
    else return 32'd0;
  endfunction

  function automatic logic [7:0] item_byte_f(input int unsigned idx, input int unsigned pos);
    if (idx == 0) return (pos == 0) ? 8'(1 << FEATURE_DMA_BIT) : 8'h00;
    else return 8'(idx * 16 + pos) ^ 8'h3C;
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [63:0] bswap64(input logic [63:0] v);
    return {bswap32(v[31:0]), bswap32(v[63:32])};
  endfunction
endpackage

// File: rtl/cfgfe_item_store.sv
module cfgfe_item_store
  import cfgfe_pkg::*;
#(
  parameter int N_ITEMS   = 4,
  parameter int ITEM_STEP = 5,
  parameter int SEL_W     = 16,
  parameter int OFF_W     = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [OFF_W-1:0] off,
  output logic [OFF_W-1:0] len,
  output logic [BUS_W-1:0] window
);
  logic [31:0] len_full;
  assign len_full = item_len_f(32'(sel), N_ITEMS, ITEM_STEP);
  assign len      = OFF_W'(len_full);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [OFF_W:0] pos;
    assign pos = {1'b0, off} + (OFF_W+1)'(b);
    assign window[8*b +: 8] = (pos < {1'b0, len}) ?
                              item_byte_f(32'(sel), 32'(pos)) : 8'h00;
  end
endmodule

// File: rtl/cfgfe_cursor.sv
module cfgfe_cursor #(
  parameter int SEL_W = 16,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [SEL_W-1:0] set_idx,
  input  logic             adv_en,
  input  logic [OFF_W-1:0] adv_len,
  input  logic [OFF_W-1:0] limit,
  output logic [SEL_W-1:0] sel_q,
  output logic [OFF_W-1:0] off_q
);
  logic [OFF_W:0] sum;
  assign sum = {1'b0, off_q} + {1'b0, adv_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      off_q <= '0;
    end else if (set_en) begin
      sel_q <= set_idx;
      off_q <= '0;
    end else if (adv_en) begin
      off_q <= (sum > {1'b0, limit}) ? limit : sum[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/cfgfe_dma_addr.sv
module cfgfe_dma_addr
  import cfgfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              wr_full,
  input  logic [BUS_W-1:0]  wimg,
  input  logic              done,
  output logic [DESC_W-1:0] addr_q,
  output logic              busy_q,
  output logic              start_q
);
  localparam int HALF = DESC_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (busy_q) begin
        if (done) begin
          addr_q <= '0;
          busy_q <= 1'b0;
        end
      end else if (wr_full) begin
        addr_q  <= bswap64(wimg[DESC_W-1:0]);
        busy_q  <= 1'b1;
        start_q <= 1'b1;
      end else if (wr_lo) begin
        addr_q[HALF-1:0] <= bswap32(wimg[HALF-1:0]);
        busy_q  <= 1'b1;
        start_q <= 1'b1;
      end else if (wr_hi) begin
        addr_q[DESC_W-1:HALF] <= bswap32(wimg[HALF-1:0]);
      end
    end
  end
endmodule

// File: rtl/cfgfe_top.sv
module cfgfe_top
  import cfgfe_pkg::*;
#(
  parameter int N_ITEMS   = 4,
  parameter int ITEM_STEP = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic        bus_write,
  input  logic [4:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [63:0] bus_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_rdata,
  output logic        dma_start,
  output logic [63:0] dma_desc,
  output logic        dma_busy,
  input  logic        dma_done,
  input  logic        dma_sel_en,
  input  logic [15:0] dma_sel_idx,
  input  logic        dma_adv_en,
  input  logic [15:0] dma_adv_len,
  output logic [15:0] cur_item,
  output logic [15:0] cur_offset,
  output logic [15:0] cur_length
);
  localparam int SEL_W = 16;
  localparam int OFF_W = 16;

  logic              acc, rd_acc, wr_acc;
  logic [31:0]       a_word;
  logic [31:0]       nbytes;
  logic              in_data, in_sel, in_desc;
  logic              sel_wr, data_rd;
  logic              desc_hi, desc_lo, desc_full;
  logic [BUS_W-1:0]  win;
  logic [BUS_W-1:0]  desc_img;
  logic [BUS_W-1:0]  rd_img;
  logic [OFF_W-1:0]  item_len;
  logic              set_en, adv_en;
  logic [SEL_W-1:0]  set_idx;
  logic [OFF_W-1:0]  adv_len;

  // Request acceptance: one read in flight, and the side port has the cursor.
  assign bus_ready = !rsp_valid && !dma_sel_en && !dma_adv_en;
  assign acc       = bus_valid && bus_ready;
  assign rd_acc    = acc && !bus_write;
  assign wr_acc    = acc && bus_write;

  assign a_word  = 32'(bus_addr);
  assign nbytes  = 32'd1 << bus_size;
  assign in_data = a_word < 32'(SEL_BASE);
  assign in_sel  = (a_word >= 32'(SEL_BASE)) && (a_word < 32'(SEL_BASE + SEL_BYTES));
  assign in_desc = (a_word >= 32'(DESC_BASE)) && (a_word < 32'(WIN_BYTES));

  assign sel_wr    = wr_acc && (a_word == 32'(SEL_BASE)) && (nbytes == 32'd2);
  assign data_rd   = rd_acc && in_data;
  assign desc_hi   = wr_acc && (a_word == 32'(DESC_BASE)) && (nbytes == 32'd4);
  assign desc_lo   = wr_acc && (a_word == 32'(HALF_LO)) && (nbytes == 32'd4);
  assign desc_full = wr_acc && (a_word == 32'(DESC_BASE)) && (nbytes == 32'(DESC_BYTES));

  // Shared cursor: side port first, select over advance.
  assign set_en  = dma_sel_en || sel_wr;
  assign set_idx = dma_sel_en ? dma_sel_idx : bus_wdata[SEL_W-1:0];
  assign adv_en  = dma_adv_en || data_rd;
  assign adv_len = dma_adv_en ? dma_adv_len : OFF_W'(nbytes);

  cfgfe_cursor #(.SEL_W(SEL_W), .OFF_W(OFF_W)) i_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_idx (set_idx),
    .adv_en  (adv_en),
    .adv_len (adv_len),
    .limit   (item_len),
    .sel_q   (cur_item),
    .off_q   (cur_offset)
  );

  cfgfe_item_store #(
    .N_ITEMS(N_ITEMS), .ITEM_STEP(ITEM_STEP), .SEL_W(SEL_W), .OFF_W(OFF_W)
  ) i_store (
    .sel    (cur_item),
    .off    (cur_offset),
    .len    (item_len),
    .window (win)
  );
  assign cur_length = item_len;

  cfgfe_dma_addr i_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (desc_hi),
    .wr_lo   (desc_lo),
    .wr_full (desc_full),
    .wimg    (bus_wdata),
    .done    (dma_done),
    .addr_q  (dma_desc),
    .busy_q  (dma_busy),
    .start_q (dma_start)
  );

  assign desc_img = bswap64(dma_desc);

  // Read lane assembly by region, masked to the access width.
  always_comb begin
    rd_img = '0;
    for (int b = 0; b < LANES; b++) begin
      if (32'(b) < nbytes) begin
        if (in_data)
          rd_img[8*b +: 8] = win[8*b +: 8];
        else if (in_sel && (a_word - 32'(SEL_BASE) + 32'(b)) < 32'(SEL_BYTES))
          rd_img[8*b +: 8] = cur_item[8*(a_word - 32'(SEL_BASE) + 32'(b)) +: 8];
        else if (in_desc && (a_word - 32'(DESC_BASE) + 32'(b)) < 32'(DESC_BYTES))
          rd_img[8*b +: 8] = desc_img[8*(a_word - 32'(DESC_BASE) + 32'(b)) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_img;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgfe_checks.sv
module cfgfe_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_rdata,
  input logic        dma_start,
  input logic [63:0] dma_desc,
  input logic        dma_busy,
  input logic        dma_done,
  input logic        dma_sel_en,
  input logic        dma_adv_en,
  input logic [15:0] cur_offset,
  input logic [15:0] cur_length
);
  a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> dma_busy);

  a_r8_busy_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_busy) |-> dma_start);

  a_r8_desc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && !dma_done) |=> (dma_busy && $stable(dma_desc)));

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && dma_done) |=> (!dma_busy && dma_desc == 64'd0));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r10_side_stalls_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_sel_en || dma_adv_en) |-> !bus_ready);

  a_r4_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cur_offset <= cur_length);
endmodule

bind cfgfe_top cfgfe_checks i_checks (.*);

// File: tb/test_cfgfe_top.sv
module test_cfgfe_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_ITEMS    = 4;
  localparam int ITEM_STEP  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [63:0] rsp_rdata;
  logic        dma_start, dma_busy;
  logic [63:0] dma_desc;
  logic        dma_done = 1'b0, dma_sel_en = 1'b0, dma_adv_en = 1'b0;
  logic [15:0] dma_sel_idx = '0, dma_adv_len = '0;
  logic [15:0] cur_item, cur_offset, cur_length;

  cfgfe_top #(.N_ITEMS(N_ITEMS), .ITEM_STEP(ITEM_STEP)) i_cfgfe_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] m_sel = '0, m_off = '0;
  logic [63:0] m_addr = '0;
  bit          m_busy = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int mlen(input int s);
    if (s == 0) return 4;
    else if (s < N_ITEMS) return s * ITEM_STEP;
    else return 0;
  endfunction

  function automatic logic [7:0] mbyte(input int s, input int p);
    if (s == 0) return (p == 0) ? 8'h02 : 8'h00;
    return 8'((s * 16 + p) % 256) ^ 8'h3C;
  endfunction

  function automatic logic [31:0] sw32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = v[8*(3-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] exp_read(input int a, input int sz);
    logic [63:0] r = '0;
    int n = 1 << sz;
    for (int b = 0; b < n; b++) begin
      if (a < 8)
        r[8*b +: 8] = (int'(m_off) + b < mlen(m_sel)) ? mbyte(m_sel, int'(m_off) + b) : 8'h00;
      else if (a < 10 && a - 8 + b < 2)
        r[8*b +: 8] = m_sel[8*(a-8+b) +: 8];
      else if (a >= 12 && a < 20 && a - 12 + b < 8)
        r[8*b +: 8] = m_addr[8*(7-(a-12+b)) +: 8];
    end
    return r;
  endfunction

  function automatic logic [15:0] sat(input int o, input int n, input int l);
    return (o + n > l) ? 16'(l) : 16'(o + n);
  endfunction

  task automatic do_read(input int a, input int sz, input int hold, input string req);
    logic [63:0] exp;
    exp = exp_read(a, sz);
    if (a < 8) m_off = sat(m_off, 1 << sz, mlen(m_sel));
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 5'(a); bus_size = 2'(sz);
    @(negedge clk);
    bus_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R11 response valid", 64'(rsp_valid), 64'd1);
    chk(bus_ready === 1'b0, "R11 ready low while pending", 64'(bus_ready), 64'd0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_rdata === exp, "R11 held response", rsp_rdata, exp);
    end
    chk(rsp_rdata === exp, req, rsp_rdata, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0, "R11 response retired", 64'(rsp_valid), 64'd0);
  endtask

  task automatic do_write(input int a, input int sz, input logic [63:0] d, input string req);
    bit trig = 1'b0;
    if (a == 8 && sz == 1) begin m_sel = d[15:0]; m_off = '0; end
    if (!m_busy) begin
      if (a == 12 && sz == 2) m_addr[63:32] = sw32(d[31:0]);
      else if (a == 16 && sz == 2) begin m_addr[31:0] = sw32(d[31:0]); trig = 1'b1; end
      else if (a == 12 && sz == 3) begin m_addr = {sw32(d[31:0]), sw32(d[63:32])}; trig = 1'b1; end
      if (trig) m_busy = 1'b1;
    end
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'(a); bus_size = 2'(sz); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk(dma_start === trig, {req, " start pulse"}, 64'(dma_start), 64'(trig));
    chk(dma_desc === m_addr, {req, " descriptor"}, dma_desc, m_addr);
    chk(cur_item === m_sel && cur_offset === m_off, {req, " cursor"}, {cur_item, cur_offset}, {m_sel, m_off});
    @(negedge clk);
    chk(dma_start === 1'b0, "R7 pulse ends", 64'(dma_start), 64'd0);
  endtask

  task automatic do_done(input string req);
    if (m_busy) begin m_busy = 1'b0; m_addr = '0; end
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    chk(dma_busy === m_busy && dma_desc === m_addr, req, {63'(dma_busy), 1'b0} | dma_desc, m_addr);
  endtask

  task automatic side_sel(input int idx);
    m_sel = 16'(idx); m_off = '0;
    @(negedge clk); dma_sel_en = 1'b1; dma_sel_idx = 16'(idx);
    #1 chk(bus_ready === 1'b0, "R10 bus stalled on select", 64'(bus_ready), 64'd0);
    @(negedge clk); dma_sel_en = 1'b0;
    chk(cur_item === m_sel && cur_offset === 16'd0 && cur_length === 16'(mlen(idx)),
        "R10 side select", {cur_item, cur_offset, cur_length}, {m_sel, 16'd0, 16'(mlen(idx))});
  endtask

  task automatic side_adv(input int n);
    m_off = sat(m_off, n, mlen(m_sel));
    @(negedge clk); dma_adv_en = 1'b1; dma_adv_len = 16'(n);
    #1 chk(bus_ready === 1'b0, "R10 bus stalled on advance", 64'(bus_ready), 64'd0);
    @(negedge clk); dma_adv_en = 1'b0;
    chk(cur_offset === m_off, "R10 side advance", cur_offset, m_off);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && dma_busy === 1'b0 && dma_start === 1'b0, "R1 idle outputs",
        {rsp_valid, dma_busy, dma_start}, 64'd0);
    chk(dma_desc === 64'd0, "R1 descriptor zero", dma_desc, 64'd0);
    chk(cur_item === 16'd0 && cur_offset === 16'd0 && cur_length === 16'd4, "R1 cursor",
        {cur_item, cur_offset, cur_length}, {16'd0, 16'd0, 16'd4});

    do_read(0, 2, 0, "R5 feature item value");
    do_read(3, 0, 0, "R4 read past end is zero");
    do_write(8, 1, 64'h3, "R3 select item 3");
    do_read(8, 1, 0, "R3 selector readback");
    do_read(0, 3, 3, "R4 first eight bytes");
    do_write(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R12 data write ignored");
    do_read(5, 3, 1, "R4 straddling read");
    do_read(0, 1, 0, "R4 saturated offset");
    do_write(8, 1, 64'h5, "R5 absent item");
    do_read(0, 3, 0, "R5 absent item reads zero");
    do_write(9, 0, 64'h1, "R2 odd selector write ignored");
    do_read(20, 3, 0, "R2 unmapped read zero");
    do_write(10, 1, 64'h2, "R2 unmapped write ignored");

    do_write(12, 2, 64'h4433_2211, "R7 upper half no launch");
    do_read(12, 3, 0, "R6 big-endian image");
    do_write(16, 2, 64'h8877_6655, "R7 lower half launch");
    do_write(16, 2, 64'h1234_5678, "R8 write while busy");
    do_write(12, 3, 64'hDEAD_BEEF_0BAD_F00D, "R8 full write while busy");
    do_read(14, 2, 0, "R6 partial image read");
    do_done("R9 done clears");
    do_done("R9 done while idle");
    do_read(12, 3, 0, "R9 register reads zero");
    do_write(12, 3, 64'h0807_0605_0403_0201, "R7 single wide launch");
    do_done("R9 done after wide launch");

    side_sel(2);
    side_adv(3);
    do_read(0, 2, 0, "R10 bus sees side cursor");
    side_adv(100);
    do_read(0, 0, 0, "R10 saturated by side advance");
    side_sel(0);

    for (int i = 0; i < 600; i++) begin
      case ($urandom % 9)
        0: do_write(8, 1, 64'($urandom % 6), "R3 random select");
        1, 2: do_read($urandom % 8, $urandom % 4, $urandom % 3, "R4 random data read");
        3: do_write(12, 2, {$urandom, $urandom}, "R7 random upper");
        4: do_write(16, 2, {$urandom, $urandom}, "R7 random lower");
        5: do_done("R9 random done");
        6: side_adv($urandom % 9);
        7: do_read(8 + $urandom % 12, $urandom % 4, 0, "R6 random register read");
        default: begin
          if ($urandom % 2) side_sel($urandom % 6);
          else do_write(12, 3, {$urandom, $urandom}, "R7 random wide");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule